// File: doc/BRIEF.md
# Selectable System Clock Generator

This block derives three system clocks and one external clock output from three incoming clock sources: a slow crystal clock, an optional fast crystal clock and an internal oscillator. The master clock can take any of the three sources and then divides it by 1, 2, 4 or 8. The sub-main clock picks either the fast crystal or the internal oscillator and is not divided. The auxiliary clock is always the slow crystal. A separate external copy of the auxiliary clock passes through its own power-of-two divider.

A single configuration register, written on the register clock, holds both source selections and both divide codes. Changing a source never produces a runt pulse. A small state machine in the register domain runs a request and acknowledge handshake with one gating branch per source. Each gating branch resynchronizes its request into its own source clock with two flops. It then changes its enable only on the falling edge of that source. The state machine has three states. SW_RUN holds steady. It moves to SW_DRAIN when the requested source differs from the current one, and drops every request at that point. SW_DRAIN moves to SW_ENGAGE once every branch acknowledges that it has stopped, and raises the request of the new source. SW_ENGAGE moves back to SW_RUN once the new branch acknowledges it is running. Reset enters SW_ENGAGE with the internal oscillator as target.

Each divider runs a free counter on its input clock. A new ratio is adopted only on a falling edge while the counter is zero. At that moment every candidate tap is low.

Top module: `sysclk_gen`

## Requirements
- R1: `aclk` always equals `lf_clk`. No register setting affects it.
- R2: `aclk_ext` has the period of `lf_clk` multiplied by 1, 2, 4 or 8. This is set by register bits [6:5], where code 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8.
- R3: Register bits [1:0] select the `mclk` source. Code 00 selects `lf_clk`, 01 selects `xt2_clk`, and 10 or 11 select `dco_clk`.
- R4: Register bits [3:2] divide `mclk` by 1, 2, 4 or 8, using the same encoding as R2.
- R5: Register bit 4 selects the `smclk` source. A value of 0 selects `dco_clk` and 1 selects `xt2_clk`.
- R6: After reset the register holds 7'h02. `mclk` and `smclk` then run at the `dco_clk` period, and `aclk_ext` runs at the `lf_clk` period.
- R7: With `HAS_XT2` = 0, every selection that names `xt2_clk` yields `dco_clk` instead, for both `mclk` and `smclk`.
- R8: At most one source is gated onto each output. A gate changes only while its own source is low. No high or low phase of `mclk` or `smclk` is shorter than the shortest half period of the sources.
- R9: A divide-ratio change takes effect only at the counter wrap while the source is low. No `aclk_ext` phase is then shorter than half an `lf_clk` period.
- R10: Once a switch has completed, exactly one source acknowledges that it is running. The output period is then exactly the selected source period times the ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_clk | input | 1 | Register and switch-control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lf_clk | input | 1 | Slow crystal source |
| xt2_clk | input | 1 | Optional fast crystal source |
| dco_clk | input | 1 | Internal oscillator source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | Configuration value: [1:0] master source, [3:2] master divide, [4] sub-main source, [6:5] auxiliary divide |
| aclk | output | 1 | Auxiliary clock |
| aclk_ext | output | 1 | Divided external copy of the auxiliary clock |
| mclk | output | 1 | Master clock |
| smclk | output | 1 | Sub-main clock |

## Verification
The bench sweeps all sixteen combinations of master source code and master divide code. In the same writes it toggles the sub-main selection and steps the auxiliary divide in the opposite direction. Every output period is measured against the arithmetic product of source period and ratio. The sweep checks that each code reaches the right source and the right tap. It also checks that the reserved master source code aliases the oscillator. A second instance without the fast crystal receives the same writes, which shows the fallback mapping. Minimum pulse widths are recorded across every switch and ratio change, so any runt pulse from a slow-to-fast or fast-to-slow transition is exposed.

// File: rtl/sysclk_pkg.sv
`timescale 1ns/100ps
package sysclk_pkg;
    localparam int DIV_W = 2;
    localparam int CNT_W = (1 << DIV_W) - 1;

    typedef enum logic [1:0] {
        SW_RUN    = 2'd0,
        SW_DRAIN  = 2'd1,
        SW_ENGAGE = 2'd2
    } sw_state_e;

    typedef struct packed {
        logic [DIV_W-1:0] aux_div;
        logic             sm_src;
        logic [DIV_W-1:0] m_div;
        logic [1:0]       m_src;
    } cfg_t;

    localparam int   CFG_W   = $bits(cfg_t);
    localparam cfg_t CFG_RST = '{aux_div: '0, sm_src: 1'b0, m_div: '0, m_src: 2'b10};
endpackage

// File: rtl/sysclk_sync.sv
`timescale 1ns/100ps
module sysclk_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= '0;
            q  <= '0;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end
endmodule

// File: rtl/sysclk_pow2_div.sv
`timescale 1ns/100ps
module sysclk_pow2_div
    import sysclk_pkg::*;
(
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] code_in,
    output logic             clk_out
);
    logic [DIV_W-1:0] code_s;
    logic [DIV_W-1:0] act_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tap;

    // bring the ratio code into the divided clock's own domain
    sysclk_sync #(.W(DIV_W)) u_code (
        .clk   (clk_in),
        .rst_n (rst_n),
        .d     (code_in),
        .q     (code_s)
    );

    // free-running counter; every ratio's period ends when it wraps
    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + CNT_W'(1);
    end

    // ratio adopted on a falling edge at count zero: all taps are low then
    always_ff @(negedge clk_in or negedge rst_n) begin
        if (!rst_n)            act_q <= '0;
        else if (cnt_q == '0)  act_q <= code_s;
    end

    always_comb begin
        tap = clk_in;
        if (act_q != '0) tap = cnt_q[act_q - DIV_W'(1)];
    end

    assign clk_out = tap;
endmodule

// File: rtl/sysclk_gf_mux.sv
`timescale 1ns/100ps
module sysclk_gf_mux
    import sysclk_pkg::*;
#(
    parameter int N   = 3,
    parameter int DEF = N - 1,
    localparam int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          ctl_clk,
    input  logic          rst_n,
    input  logic [N-1:0]  src_clk,
    input  logic [SW-1:0] sel,
    output logic          clk_out,
    output logic [N-1:0]  gate_o,
    output logic [N-1:0]  ack_o,
    output logic          busy_o
);
    sw_state_e     st_q, st_d;
    logic [SW-1:0] cur_q, tgt_q;
    logic [N-1:0]  req_q;
    logic [N-1:0]  ack_w;
    logic [N-1:0]  gated;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SW_RUN:    if (sel != cur_q)  st_d = SW_DRAIN;
            SW_DRAIN:  if (ack_w == '0)   st_d = SW_ENGAGE;
            SW_ENGAGE: if (ack_w[tgt_q])  st_d = SW_RUN;
            default:                      st_d = SW_RUN;
        endcase
    end

    // state register
    always_ff @(posedge ctl_clk or negedge rst_n) begin
        if (!rst_n) st_q <= SW_ENGAGE;
        else        st_q <= st_d;
    end

    // outputs of the controller: current source, target, requests
    always_ff @(posedge ctl_clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= SW'(DEF);
            tgt_q <= SW'(DEF);
            req_q <= N'(1) << DEF;
        end else begin
            unique case (st_q)
                SW_RUN: if (st_d == SW_DRAIN) begin
                    tgt_q <= sel;
                    req_q <= '0;
                end
                SW_DRAIN: if (st_d == SW_ENGAGE) begin
                    req_q <= N'(1) << tgt_q;
                end
                SW_ENGAGE: if (st_d == SW_RUN) begin
                    cur_q <= tgt_q;
                end
                default: begin
                    req_q <= '0;
                end
            endcase
        end
    end

    // one gating branch per source
    for (genvar g = 0; g < N; g++) begin : g_branch
        logic rq_s;
        logic en_q;

        sysclk_sync #(.W(1)) u_req (
            .clk   (src_clk[g]),
            .rst_n (rst_n),
            .d     (req_q[g]),
            .q     (rq_s)
        );

        always_ff @(negedge src_clk[g] or negedge rst_n) begin
            if (!rst_n) en_q <= 1'b0;
            else        en_q <= rq_s;
        end

        sysclk_sync #(.W(1)) u_ack (
            .clk   (ctl_clk),
            .rst_n (rst_n),
            .d     (en_q),
            .q     (ack_w[g])
        );

        assign gated[g]  = src_clk[g] & en_q;
        assign gate_o[g] = en_q;
    end

    assign clk_out = |gated;
    assign ack_o   = ack_w;
    assign busy_o  = (st_q != SW_RUN);
endmodule

// File: rtl/sysclk_gen.sv
`timescale 1ns/100ps
module sysclk_gen
    import sysclk_pkg::*;
#(
    parameter bit HAS_XT2 = 1'b1
) (
    input  logic             reg_clk,
    input  logic             rst_n,
    input  logic             lf_clk,
    input  logic             xt2_clk,
    input  logic             dco_clk,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             aclk,
    output logic             aclk_ext,
    output logic             mclk,
    output logic             smclk
);
    localparam int M_N   = 3;
    localparam int S_N   = 2;
    localparam int M_SW  = $clog2(M_N);
    localparam int S_SW  = $clog2(S_N);

    cfg_t            cfg_q;
    logic [M_SW-1:0] m_sel;
    logic [S_SW-1:0] s_sel;
    logic            xt2_eff;
    logic            mclk_raw;
    logic [M_N-1:0]  m_gate, m_ack;
    logic [S_N-1:0]  s_gate, s_ack;
    logic            m_busy, s_busy;

    always_ff @(posedge reg_clk or negedge rst_n) begin
        if (!rst_n)      cfg_q <= CFG_RST;
        else if (cfg_we) cfg_q <= cfg_t'(cfg_wdata);
    end

    assign xt2_eff = HAS_XT2 ? xt2_clk : 1'b0;

    // master branch order: 0 slow crystal, 1 fast crystal, 2 oscillator
    always_comb begin
        unique case (cfg_q.m_src)
            2'b00:   m_sel = M_SW'(0);
            2'b01:   m_sel = HAS_XT2 ? M_SW'(1) : M_SW'(2);
            default: m_sel = M_SW'(2);
        endcase
    end

    // sub-main branch order: 0 oscillator, 1 fast crystal
    assign s_sel = S_SW'(cfg_q.sm_src & HAS_XT2);

    sysclk_gf_mux #(.N(M_N), .DEF(2)) u_mmux (
        .ctl_clk (reg_clk),
        .rst_n   (rst_n),
        .src_clk ({dco_clk, xt2_eff, lf_clk}),
        .sel     (m_sel),
        .clk_out (mclk_raw),
        .gate_o  (m_gate),
        .ack_o   (m_ack),
        .busy_o  (m_busy)
    );

    sysclk_gf_mux #(.N(S_N), .DEF(0)) u_smux (
        .ctl_clk (reg_clk),
        .rst_n   (rst_n),
        .src_clk ({xt2_eff, dco_clk}),
        .sel     (s_sel),
        .clk_out (smclk),
        .gate_o  (s_gate),
        .ack_o   (s_ack),
        .busy_o  (s_busy)
    );

    sysclk_pow2_div u_mdiv (
        .clk_in  (mclk_raw),
        .rst_n   (rst_n),
        .code_in (cfg_q.m_div),
        .clk_out (mclk)
    );

    sysclk_pow2_div u_adiv (
        .clk_in  (lf_clk),
        .rst_n   (rst_n),
        .code_in (cfg_q.aux_div),
        .clk_out (aclk_ext)
    );

    assign aclk = lf_clk;
endmodule

// File: rtl/sysclk_gen_chk.sv
`timescale 1ns/100ps
module sysclk_gen_chk (
    input logic       reg_clk,
    input logic       rst_n,
    input logic       lf_clk,
    input logic       xt2_clk,
    input logic       dco_clk,
    input logic [2:0] m_gate,
    input logic [1:0] s_gate,
    input logic [2:0] m_ack,
    input logic [1:0] s_ack,
    input logic       m_busy,
    input logic       s_busy
);
    logic [1:0] hi_d;
    logic       hi_l;
    logic [1:0] hi_x;

    // R8
    m_onehot_chk: assert property (@(posedge reg_clk) disable iff (!rst_n)
        $onehot0(m_gate)) else $error("master gates overlap");

    // R8
    s_onehot_chk: assert property (@(posedge reg_clk) disable iff (!rst_n)
        $onehot0(s_gate)) else $error("sub-main gates overlap");

    // R10
    m_settled_chk: assert property (@(posedge reg_clk) disable iff (!rst_n)
        !m_busy |-> ($countones(m_ack) == 1)) else $error("master not settled");

    // R10
    s_settled_chk: assert property (@(posedge reg_clk) disable iff (!rst_n)
        !s_busy |-> ($countones(s_ack) == 1)) else $error("sub-main not settled");

    // gate values at the start of each high phase
    always_ff @(posedge dco_clk or negedge rst_n) begin
        if (!rst_n) hi_d <= '0;
        else        hi_d <= {m_gate[2], s_gate[0]};
    end
    always_ff @(posedge lf_clk or negedge rst_n) begin
        if (!rst_n) hi_l <= 1'b0;
        else        hi_l <= m_gate[0];
    end
    always_ff @(posedge xt2_clk or negedge rst_n) begin
        if (!rst_n) hi_x <= '0;
        else        hi_x <= {m_gate[1], s_gate[1]};
    end

    // gates must hold across the whole high phase of their source
    always_ff @(negedge dco_clk) begin
        if (rst_n) begin
            // R8
            dco_gate_hold_chk: assert ({m_gate[2], s_gate[0]} == hi_d)
                else $error("oscillator gate moved while high");
        end
    end
    always_ff @(negedge lf_clk) begin
        if (rst_n) begin
            // R8
            lf_gate_hold_chk: assert (m_gate[0] == hi_l)
                else $error("slow crystal gate moved while high");
        end
    end
    always_ff @(negedge xt2_clk) begin
        if (rst_n) begin
            // R8
            xt2_gate_hold_chk: assert ({m_gate[1], s_gate[1]} == hi_x)
                else $error("fast crystal gate moved while high");
        end
    end
endmodule

bind sysclk_gen sysclk_gen_chk u_chk (
    .reg_clk (reg_clk),
    .rst_n   (rst_n),
    .lf_clk  (lf_clk),
    .xt2_clk (xt2_clk),
    .dco_clk (dco_clk),
    .m_gate  (m_gate),
    .s_gate  (s_gate),
    .m_ack   (m_ack),
    .s_ack   (s_ack),
    .m_busy  (m_busy),
    .s_busy  (s_busy)
);

// File: tb/sysclk_gen_bench.sv
`timescale 1ns/100ps
module sysclk_gen_probe (
    input  logic   clk,
    input  int     epoch,
    output longint per,
    output longint min_hi,
    output longint min_lo,
    output int     edges
);
    longint per_r   = 0;
    longint mhi_r   = 0;
    longint mlo_r   = 0;
    int     edg_r   = 0;
    longint t_rise  = 0;
    longint t_fall  = 0;
    bit     seen_r  = 1'b0;
    bit     seen_f  = 1'b0;
    int     seen_ep = -1;

    always @(clk) begin
        if (seen_ep != epoch) begin
            seen_ep = epoch;
            mhi_r   = 64'd1000000;
            mlo_r   = 64'd1000000;
        end
        if (clk === 1'b1) begin
            if (seen_r) per_r = longint'($time) - t_rise;
            if (seen_f && (longint'($time) - t_fall) < mlo_r)
                mlo_r = longint'($time) - t_fall;
            seen_r = 1'b1;
            t_rise = longint'($time);
            edg_r  = edg_r + 1;
        end else if (clk === 1'b0 && seen_r) begin
            if ((longint'($time) - t_rise) < mhi_r)
                mhi_r = longint'($time) - t_rise;
            seen_f = 1'b1;
            t_fall = longint'($time);
        end
    end

    assign per    = per_r;
    assign min_hi = mhi_r;
    assign min_lo = mlo_r;
    assign edges  = edg_r;
endmodule

module sysclk_gen_bench;
    localparam int REG_PERIOD = 12;
    localparam int DCO_HALF   = 5;
    localparam int XT2_HALF   = 7;
    localparam int LF_HALF    = 40;
    localparam int NPROBE     = 7;

    logic       reg_clk = 1'b0;
    logic       lf_clk  = 1'b0;
    logic       xt2_clk = 1'b0;
    logic       dco_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic       cfg_we  = 1'b0;
    logic [6:0] cfg_wdata = 7'h00;

    logic aclk, aclk_ext, mclk, smclk;
    logic n_aclk, n_aclk_ext, n_mclk, n_smclk;

    int     n_chk = 0;
    int     n_bad = 0;
    int     epoch = 0;
    bit     done  = 1'b0;
    longint per_v [NPROBE];
    longint mhi_v [NPROBE];
    longint mlo_v [NPROBE];
    int     edg_v [NPROBE];
    int     snap  [NPROBE];
    logic [NPROBE-1:0] pclk;

    always #(REG_PERIOD/2) reg_clk = ~reg_clk;
    always #(DCO_HALF)     dco_clk = ~dco_clk;
    always #(XT2_HALF)     xt2_clk = ~xt2_clk;
    always #(LF_HALF)      lf_clk  = ~lf_clk;

    sysclk_gen u_sysclk_gen (
        .reg_clk (reg_clk), .rst_n (rst_n),
        .lf_clk (lf_clk), .xt2_clk (xt2_clk), .dco_clk (dco_clk),
        .cfg_we (cfg_we), .cfg_wdata (cfg_wdata),
        .aclk (aclk), .aclk_ext (aclk_ext), .mclk (mclk), .smclk (smclk)
    );

    sysclk_gen #(.HAS_XT2(1'b0)) u_sysclk_gen_nox (
        .reg_clk (reg_clk), .rst_n (rst_n),
        .lf_clk (lf_clk), .xt2_clk (1'b0), .dco_clk (dco_clk),
        .cfg_we (cfg_we), .cfg_wdata (cfg_wdata),
        .aclk (n_aclk), .aclk_ext (n_aclk_ext), .mclk (n_mclk), .smclk (n_smclk)
    );

    // 0 mclk, 1 smclk, 2 aclk, 3 aclk_ext, 4..6 the instance without fast crystal
    assign pclk = {n_aclk_ext, n_smclk, n_mclk, aclk_ext, aclk, smclk, mclk};

    for (genvar i = 0; i < NPROBE; i++) begin : g_probe
        sysclk_gen_probe u_probe (
            .clk (pclk[i]), .epoch (epoch),
            .per (per_v[i]), .min_hi (mhi_v[i]), .min_lo (mlo_v[i]), .edges (edg_v[i])
        );
    end

    task automatic check_eq(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_ge(input string req, input string what, input longint act, input longint lim);
        n_chk++;
        if (act < lim) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected >= %0d", req, what, act, lim);
        end
    endtask

    function automatic longint fresh_per(input int idx);
        return (edg_v[idx] - snap[idx] >= 2) ? per_v[idx] : 64'd0;
    endfunction

    function automatic longint m_src_per(input int code, input bit has_x);
        if (code == 0) return longint'(2 * LF_HALF);
        if (code == 1 && has_x) return longint'(2 * XT2_HALF);
        return longint'(2 * DCO_HALF);
    endfunction

    task automatic write_cfg(input logic [6:0] v);
        @(negedge reg_clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge reg_clk);
        cfg_we    = 1'b0;
    endtask

    task automatic settle_and_snap();
        #6000.5;
        for (int i = 0; i < NPROBE; i++) snap[i] = edg_v[i];
        #1500;
    endtask

    initial begin
        longint lf_per;
        lf_per = longint'(2 * LF_HALF);
        #100.5;
        rst_n = 1'b1;
        settle_and_snap();

        // R6 reset state
        check_eq("R6", "reset mclk period", fresh_per(0), longint'(2 * DCO_HALF));
        check_eq("R6", "reset smclk period", fresh_per(1), longint'(2 * DCO_HALF));
        check_eq("R6", "reset aclk_ext period", fresh_per(3), lf_per);
        check_eq("R6", "reset mclk period, no fast crystal", fresh_per(4), longint'(2 * DCO_HALF));
        check_eq("R1", "aclk period", fresh_per(2), lf_per);
        check_eq("R1", "aclk level", longint'(aclk), longint'(lf_clk));

        for (int s = 0; s < 4; s++) begin
            for (int d = 0; d < 4; d++) begin
                logic [1:0] aux;
                logic       sm;
                logic [6:0] v;
                longint     exp_m, exp_s, exp_mn, exp_sn, exp_a;
                aux = 2'(3 - d);
                sm  = d[0];
                v   = {aux, sm, 2'(d), 2'(s)};
                exp_m  = m_src_per(s, 1'b1) << d;
                exp_mn = m_src_per(s, 1'b0) << d;
                exp_s  = sm ? longint'(2 * XT2_HALF) : longint'(2 * DCO_HALF);
                exp_sn = longint'(2 * DCO_HALF);
                exp_a  = lf_per << aux;
                epoch++;
                write_cfg(v);
                settle_and_snap();
                // R3 R4 R10: selected source and ratio, steady after the switch
                check_eq("R3 R4 R10", $sformatf("mclk period cfg=%h", v), fresh_per(0), exp_m);
                check_eq("R5", $sformatf("smclk period cfg=%h", v), fresh_per(1), exp_s);
                check_eq("R1", "aclk period", fresh_per(2), lf_per);
                check_eq("R1", "aclk level", longint'(aclk), longint'(lf_clk));
                check_eq("R2", $sformatf("aclk_ext period cfg=%h", v), fresh_per(3), exp_a);
                check_eq("R7", $sformatf("mclk fallback period cfg=%h", v), fresh_per(4), exp_mn);
                check_eq("R7", $sformatf("smclk fallback period cfg=%h", v), fresh_per(5), exp_sn);
                // R8 no runt pulse across the switch
                check_ge("R8", "mclk min high", mhi_v[0], longint'(DCO_HALF));
                check_ge("R8", "mclk min low", mlo_v[0], longint'(DCO_HALF));
                check_ge("R8", "smclk min high", mhi_v[1], longint'(DCO_HALF));
                check_ge("R8", "smclk min low", mlo_v[1], longint'(DCO_HALF));
                check_ge("R8", "fallback mclk min high", mhi_v[4], longint'(DCO_HALF));
                // R9 ratio change only at wrap
                check_ge("R9", "aclk_ext min high", mhi_v[3], longint'(LF_HALF));
                check_ge("R9", "aclk_ext min low", mlo_v[3], longint'(LF_HALF));
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule